// File: doc/BRIEF.md
# Timer Count-Enable Prescaler

This block produces the single-cycle count-enable strobe that several timers and a watchdog share. Its rate comes from a 4-bit divide field. A field value F gives one strobe every F+1 system clocks, so the rate runs from every clock (F = 0) down to one clock in sixteen (F = 15). Software changes the rate by writing a new field value. Each write restarts the internal count, so the new rate starts cleanly.

A static mode input picks the divide value that reset loads. In the compatibility setting the field resets to 5, which gives one strobe per six-clock machine cycle. In the fast setting it resets to 0, which gives one strobe every clock.

The block also drives the sample gate for the external counter and interrupt input pins. In compatibility mode those pins are sampled only on strobes. In fast mode they are sampled on every clock. A separate enable serves the third timer. When that timer runs as a clock-out or baud source it must see an undivided enable, so a bypass input forces that enable high on every clock.

Top module: `tmr_prescale`

## Requirements
- R1: With `fast_mode` = 0 during a synchronous reset, the divide field becomes 5. The first `tick` appears on the 6th rising edge after `rst` falls, and later ticks follow every 6 clocks.
- R2: With `fast_mode` = 1 during a synchronous reset, the divide field becomes 0. `tick` is then high on every clock from the first edge after `rst` falls.
- R3: With field F, `tick` is high for exactly one clock in every F+1 clocks, for every F from 0 to 15.
- R4: A write (`div_wr` = 1 at an edge, new value on `div_wdata`) restarts the count. `tick` is low in the cycle after the write edge. The first tick at the new field F comes on the (F+1)th edge after the write edge.
- R5: When `fast_mode` = 0, `pin_sample_en` is high exactly in the cycles where `tick` is high.
- R6: When `fast_mode` = 1, `pin_sample_en` is high on every clock, whatever the field value.
- R7: When `t2_bypass` = 1, `t2_en` is high on every clock. When `t2_bypass` = 0, `t2_en` follows `tick`.
- R8: While `rst` is high at a clock edge, `tick` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | 0 = compatibility mode, 1 = fast mode; held static outside reset |
| div_wr | input | 1 | Write strobe for the divide field |
| div_wdata | input | 4 | New divide field value F (ratio F+1) |
| t2_bypass | input | 1 | Third timer in clock-out or baud mode: enable undivided |
| tick | output | 1 | Shared timer and watchdog count enable |
| pin_sample_en | output | 1 | Sample gate for external counter and interrupt pins |
| t2_en | output | 1 | Count enable for the third timer |

## Verification
The assertions assume that `fast_mode` changes only while `rst` is high, because the reset-default mirror in the checker reads it only at reset. They also assume that `rst` is high on the first clock edge. The stimulus therefore changes the mode only inside a reset pulse and starts with reset asserted. Writes come at arbitrary points within a period, including back-to-back restarts and a rewrite of the same value. The bypass input is toggled freely, because nothing in the checker depends on its history.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic {
        PS_COMPAT = 1'b0,
        PS_FAST   = 1'b1
    } ps_mode_e;

endpackage

// File: rtl/tps_divider.sv
module tps_divider
    import tps_pkg::*;
#(
    parameter int unsigned DIV_W      = 4,
    parameter int unsigned COMPAT_DIV = 5,
    parameter int unsigned FAST_DIV   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  ps_mode_e         mode,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic             tick
);

    localparam logic [DIV_W-1:0] COMPAT_V = DIV_W'(COMPAT_DIV);
    localparam logic [DIV_W-1:0] FAST_V   = DIV_W'(FAST_DIV);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.div  = wdata;
            st_d.cnt  = '0;
            st_d.tick = 1'b0;
        end else if (st_q.cnt == st_q.div) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.div  <= (mode == PS_FAST) ? FAST_V : COMPAT_V;
            st_q.cnt  <= '0;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/tps_gate.sv
module tps_gate (
    input  logic force_i,
    input  logic tick_i,
    output logic en_o
);

    always_comb begin
        en_o = force_i | tick_i;
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tps_pkg::*;
#(
    parameter int unsigned DIV_W      = 4,
    parameter int unsigned COMPAT_DIV = 5,
    parameter int unsigned FAST_DIV   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fast_mode,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             t2_bypass,
    output logic             tick,
    output logic             pin_sample_en,
    output logic             t2_en
);

    ps_mode_e mode;

    assign mode = fast_mode ? PS_FAST : PS_COMPAT;

    tps_divider #(
        .DIV_W      (DIV_W),
        .COMPAT_DIV (COMPAT_DIV),
        .FAST_DIV   (FAST_DIV)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .wr    (div_wr),
        .wdata (div_wdata),
        .tick  (tick)
    );

    // external pin sampling: every clock in fast mode, else on ticks
    tps_gate u_pin_gate (
        .force_i (mode == PS_FAST),
        .tick_i  (tick),
        .en_o    (pin_sample_en)
    );

    // third timer: undivided in clock-out / baud modes
    tps_gate u_t2_gate (
        .force_i (t2_bypass),
        .tick_i  (tick),
        .en_o    (t2_en)
    );

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
    parameter int unsigned DIV_W      = 4,
    parameter int unsigned COMPAT_DIV = 5,
    parameter int unsigned FAST_DIV   = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             fast_mode,
    input logic             div_wr,
    input logic [DIV_W-1:0] div_wdata,
    input logic             t2_bypass,
    input logic             tick,
    input logic             pin_sample_en,
    input logic             t2_en
);

    logic [DIV_W-1:0] fld_q;
    logic [DIV_W:0]   gap_q;
    logic [DIV_W:0]   span;

    assign span = {1'b0, fld_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fld_q <= fast_mode ? DIV_W'(FAST_DIV) : DIV_W'(COMPAT_DIV);
            gap_q <= '0;
        end else if (div_wr) begin
            fld_q <= div_wdata;
            gap_q <= '0;
        end else if (tick) begin
            gap_q <= (DIV_W+1)'(1);
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == span);                                   // R3
    AST_NO_LATE_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |-> gap_q < span);                                   // R1
    AST_WR_RESTART: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !tick);                                         // R4
    AST_SAMPLE_COMPAT: assert property (@(posedge clk) disable iff (rst)
        !fast_mode |-> pin_sample_en == tick);                     // R5
    AST_SAMPLE_FAST: assert property (@(posedge clk) disable iff (rst)
        fast_mode |-> pin_sample_en);                              // R6
    AST_T2_BYPASS: assert property (@(posedge clk) disable iff (rst)
        t2_bypass |-> t2_en);                                      // R7
    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !tick);                                            // R8

endmodule

bind tmr_prescale tps_checker #(
    .DIV_W      (DIV_W),
    .COMPAT_DIV (COMPAT_DIV),
    .FAST_DIV   (FAST_DIV)
) u_chk (.*);

// File: tb/tmr_prescale_bench.sv
module tmr_prescale_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fast_mode = 1'b0;
    logic       div_wr = 1'b0;
    logic [3:0] div_wdata = 4'd0;
    logic       t2_bypass = 1'b0;
    logic       tick, pin_sample_en, t2_en;

    int    cyc = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    exp_q[$];
    string phase_req = "R8";

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_prescale u_tmr_prescale (
        .clk           (clk),
        .rst           (rst),
        .fast_mode     (fast_mode),
        .div_wr        (div_wr),
        .div_wdata     (div_wdata),
        .t2_bypass     (t2_bypass),
        .tick          (tick),
        .pin_sample_en (pin_sample_en),
        .t2_en         (t2_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cyc, act, exp);
        end
    endtask

    // driver side: expected tick cycles go into the scoreboard queue
    task automatic push_ticks(input int first, input int period);
        for (int t = first; t < first + 200; t += period) exp_q.push_back(t);
    endtask

    task automatic do_reset(input bit fast, input int dflt, input string req);
        @(negedge clk);
        rst = 1'b1;
        fast_mode = fast;
        exp_q.delete();
        repeat (3) @(negedge clk);
        phase_req = req;
        rst = 1'b0;
        push_ticks(cyc + 1 + dflt, dflt + 1);
    endtask

    task automatic do_write(input int v, input string req);
        @(negedge clk);
        div_wr = 1'b1;
        div_wdata = 4'(v);
        phase_req = req;
        exp_q.delete();
        push_ticks(cyc + 2 + v, v + 1);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor side: pop and compare as results appear
    initial begin
        forever begin
            bit exp_tick;
            @(posedge clk);
            #3;
            exp_tick = (exp_q.size() > 0) && (exp_q[0] == cyc);
            if (rst) begin
                check(tick == 1'b0, "R8", "tick in reset", int'(tick), 0);
            end else begin
                check(tick == exp_tick, phase_req, "tick", int'(tick), int'(exp_tick));
            end
            while (exp_q.size() > 0 && exp_q[0] <= cyc) void'(exp_q.pop_front());
            if (fast_mode)
                check(pin_sample_en == 1'b1, "R6", "pin_sample_en", int'(pin_sample_en), 1);
            else
                check(pin_sample_en == (exp_tick && !rst), "R5", "pin_sample_en",
                      int'(pin_sample_en), int'(exp_tick && !rst));
            check(t2_en == (t2_bypass || (exp_tick && !rst)), "R7", "t2_en",
                  int'(t2_en), int'(t2_bypass || (exp_tick && !rst)));
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle(2);
        do_reset(1'b0, 5, "R1");
        idle(40);
        do_write(0, "R3");
        idle(10);
        t2_bypass = 1'b1;
        do_write(15, "R3");
        idle(40);
        t2_bypass = 1'b0;
        idle(20);
        do_write(3, "R4");
        idle(7);
        do_write(3, "R4");
        idle(2);
        do_write(9, "R4");
        idle(30);
        do_reset(1'b1, 0, "R2");
        idle(10);
        do_write(6, "R6");
        idle(30);
        do_write(1, "R3");
        t2_bypass = 1'b1;
        idle(8);
        t2_bypass = 1'b0;
        idle(8);
        do_reset(1'b0, 5, "R1");
        idle(20);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule